// File: doc/BRIEF.md
# Timestamp Time Base with Coherent Split Read

This block is a free-running 40-bit counter that gives a system clock source a stable, monotonic time base. It advances by one on every cycle in which an externally supplied tick enable is high, nominally at a rate near 983 kHz. Counting starts only once software sets an enable bit, and the block has no interrupt output.

Software sees two read registers on a small word bus. The lower register returns counter bits 31..0. The upper register returns a held copy of bits 39..32 together with the enable bit. The held copy is not taken live. It is captured on the same clock edge that serves a read of the lower register. A read of the lower register followed by a read of the upper register therefore returns the two halves of one counter value, even when the count carries across the 32-bit boundary between the two accesses.

Top module: `ts_timebase`

## Requirements
- R1: After reset the counter, the held upper byte and the enable are zero, so a read of either register returns 0.
- R2: While enabled, the counter rises by exactly one on each clock edge that sees tick_en high. It holds on every other edge.
- R3: The counter wraps from all ones to zero and keeps counting.
- R4: A read at offset 0x60 (rd_en high for one cycle) puts counter bits 31..0, as they stood before that edge, on rdata one cycle later.
- R5: A read at 0x60 captures counter bits 39..32 into the held byte on the same edge. A read at 0x64 returns the held byte in rdata bits 7..0 and the enable in bit 8, with all other bits 0.
- R6: When a tick and a read at 0x60 fall in the same cycle, both the returned low word and the held byte come from the pre-increment count.
- R7: The held byte changes only on a read at 0x60. Reads at 0x64 without a new low read return the same byte while the counter moves on.
- R8: A write at 0x64 loads the enable from wdata bit 8. With the enable at 0, ticks leave the counter unchanged. Writes at 0x60 have no effect.
- R9: A read at any other offset, and any cycle with no read, gives rdata equal to 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Count advance strobe |
| rd_en | input | 1 | Read strobe for the register at addr |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | 8 | Byte offset of the accessed register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |

## Verification
Every result in this block is due on the first edge after its stimulus. A read strobe shows on rdata one cycle later. A tick with the enable set raises the count on that same edge. An enable write takes effect from the next edge on, so a tick in the write cycle itself is not counted. The bench drives each access after a falling edge. It updates its reference count, held byte and enable at the rising edge, from the values it had before that edge. It then compares rdata at the next falling edge, so each read is checked against the exact pre-increment count that R4 and R6 call for. A narrow second instance, 4+4 bits wide, is run through a full wrap with hand-computed values.

// File: rtl/ts_pkg.sv
package ts_pkg;
  parameter int unsigned TS_DATA_W = 32;
  parameter int unsigned TS_ADDR_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_LO,
    SEL_HI
  } ts_sel_e;
endpackage

// File: rtl/ts_rst_sync.sv
module ts_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter int unsigned CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = run & tick;
    cnt_d  = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ts_regif.sv
module ts_regif
  import ts_pkg::*;
#(
  parameter int unsigned LO_W    = 32,
  parameter int unsigned HI_W    = 8,
  parameter int unsigned ADDR_W  = TS_ADDR_W,
  parameter int unsigned DATA_W  = TS_DATA_W,
  parameter logic [ADDR_W-1:0] LO_OFS = 'h60,
  parameter logic [ADDR_W-1:0] HI_OFS = 'h64,
  parameter int unsigned ENA_BIT = 8,
  localparam int unsigned CNT_W  = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic              run,
  output logic [HI_W-1:0]   held,
  output logic [DATA_W-1:0] rdata
);
  ts_sel_e           sel;
  logic              run_q, run_d, run_ce;
  logic [HI_W-1:0]   held_q, held_d;
  logic              held_ce;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    if (addr == LO_OFS)      sel = SEL_LO;
    else if (addr == HI_OFS) sel = SEL_HI;
    else                     sel = SEL_NONE;
  end

  always_comb begin
    held_ce = rd_en && (sel == SEL_LO);
    held_d  = cnt[CNT_W-1:LO_W];
    run_ce  = wr_en && (sel == SEL_HI);
    run_d   = wdata[ENA_BIT];
    rdata_d = '0;
    if (rd_en) begin
      case (sel)
        SEL_LO: rdata_d[LO_W-1:0] = cnt[LO_W-1:0];
        SEL_HI: begin
          rdata_d[HI_W-1:0] = held_q;
          rdata_d[ENA_BIT]  = run_q;
        end
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      held_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (run_ce)  run_q  <= run_d;
      if (held_ce) held_q <= held_d;
      rdata_q <= rdata_d;
    end
  end

  assign run   = run_q;
  assign held  = held_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/ts_timebase.sv
module ts_timebase
  import ts_pkg::*;
#(
  parameter int unsigned LO_W    = 32,
  parameter int unsigned HI_W    = 8,
  parameter int unsigned ADDR_W  = TS_ADDR_W,
  parameter int unsigned DATA_W  = TS_DATA_W,
  parameter logic [ADDR_W-1:0] LO_OFS = 'h60,
  parameter logic [ADDR_W-1:0] HI_OFS = 'h64,
  parameter int unsigned ENA_BIT = 8,
  localparam int unsigned CNT_W  = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic             rst_sync_n;
  logic             run;
  logic [CNT_W-1:0] cnt;
  logic [HI_W-1:0]  held;

  ts_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ts_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .tick  (tick_en),
    .cnt   (cnt)
  );

  ts_regif #(
    .LO_W(LO_W), .HI_W(HI_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LO_OFS(LO_OFS), .HI_OFS(HI_OFS), .ENA_BIT(ENA_BIT)
  ) u_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .cnt   (cnt),
    .run   (run),
    .held  (held),
    .rdata (rdata)
  );
endmodule

// File: rtl/ts_timebase_chk.sv
module ts_timebase_chk #(
  parameter int unsigned LO_W    = 32,
  parameter int unsigned HI_W    = 8,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter logic [ADDR_W-1:0] LO_OFS = 'h60,
  parameter logic [ADDR_W-1:0] HI_OFS = 'h64,
  parameter int unsigned ENA_BIT = 8,
  localparam int unsigned CNT_W  = LO_W + HI_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [CNT_W-1:0]  cnt,
  input logic [HI_W-1:0]   held,
  input logic              run
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en) |=> (cnt == $past(cnt) + 1'b1));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && tick_en) |=> $stable(cnt));

  p_low_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == LO_OFS) |=> (rdata[LO_W-1:0] == $past(cnt[LO_W-1:0])));

  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == LO_OFS) |=> (held == $past(cnt[CNT_W-1:LO_W])));

  p_held_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr == LO_OFS) |=> $stable(held));

  p_enable_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == HI_OFS) |=> (run == $past(wdata[ENA_BIT])));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |=> (rdata == '0));
endmodule

bind ts_timebase ts_timebase_chk #(
  .LO_W(LO_W), .HI_W(HI_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .LO_OFS(LO_OFS), .HI_OFS(HI_OFS), .ENA_BIT(ENA_BIT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .tick_en (tick_en),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .cnt     (cnt),
  .held    (held),
  .run     (run)
);

// File: tb/sim_ts_timebase.sv
module sim_ts_timebase;
  localparam logic [7:0] LO = 8'h60;
  localparam logic [7:0] HI = 8'h64;

  logic        clk;
  logic        rst_n;
  logic        tick_en, rd_en, wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;

  logic        b_tick, b_rd, b_wr;
  logic [7:0]  b_addr;
  logic [31:0] b_wdata, b_rdata;

  int checks = 0;
  int errors = 0;

  logic [39:0] m_cnt;
  logic [7:0]  m_held;
  logic        m_run;

  ts_timebase u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rd_en(rd_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  ts_timebase #(.LO_W(4), .HI_W(4)) u1 (
    .clk(clk), .rst_n(rst_n), .tick_en(b_tick), .rd_en(b_rd),
    .wr_en(b_wr), .addr(b_addr), .wdata(b_wdata), .rdata(b_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == LO) return m_cnt[31:0];
    if (a == HI) return {23'd0, m_run, m_held};
    return 32'd0;
  endfunction

  task automatic cyc(input string req, input logic t, input logic r, input logic w,
                     input logic [7:0] a, input logic [31:0] d, input logic chk_idle);
    logic [31:0] exp;
    tick_en = t; rd_en = r; wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    exp = r ? exp_read(a) : 32'd0;
    if (r && a == LO) m_held = m_cnt[39:32];
    if (t && m_run) m_cnt = m_cnt + 40'd1;
    if (w && a == HI) m_run = d[8];
    @(negedge clk);
    tick_en = 0; rd_en = 0; wr_en = 0;
    if (r || chk_idle) check(req, rdata, exp);
  endtask

  task automatic bcyc(input logic t, input logic r, input logic w,
                      input logic [7:0] a, input logic [31:0] d);
    b_tick = t; b_rd = r; b_wr = w; b_addr = a; b_wdata = d;
    @(negedge clk);
    b_tick = 0; b_rd = 0; b_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; tick_en = 0; rd_en = 0; wr_en = 0; addr = 0; wdata = 0;
    b_tick = 0; b_rd = 0; b_wr = 0; b_addr = 0; b_wdata = 0;
    m_cnt = 0; m_held = 0; m_run = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    cyc("R1", 0, 1, 0, LO, 0, 0);
    cyc("R1", 0, 1, 0, HI, 0, 0);
    // R8 disabled: ticks do nothing, low writes ignored
    for (int i = 0; i < 5; i++) cyc("R8", 1, 0, 0, LO, 0, 0);
    cyc("R8", 0, 0, 1, LO, 32'h100, 0);
    cyc("R8", 0, 1, 0, HI, 0, 0);
    cyc("R8", 0, 1, 0, LO, 0, 0);
    // enable, tick in the write cycle not counted
    cyc("R8", 1, 0, 1, HI, 32'h100, 0);
    cyc("R8", 0, 1, 0, HI, 0, 0);
    for (int i = 0; i < 10; i++) cyc("R2", 1, 0, 0, LO, 0, 0);
    cyc("R2", 0, 1, 0, LO, 0, 0);
    // R6 coincident tick and low read
    cyc("R6", 1, 1, 0, LO, 0, 0);
    cyc("R6", 0, 1, 0, LO, 0, 0);
    cyc("R6", 0, 1, 0, HI, 0, 0);
    // R7 held byte unchanged across ticks
    for (int i = 0; i < 4; i++) cyc("R7", 1, 0, 0, LO, 0, 0);
    cyc("R7", 0, 1, 0, HI, 0, 0);
    // R9 unmapped and idle
    cyc("R9", 1, 1, 0, 8'h68, 0, 0);
    cyc("R9", 1, 0, 0, LO, 0, 1);
    // disable again, R8 hold
    cyc("R8", 0, 0, 1, HI, 32'h0, 0);
    for (int i = 0; i < 3; i++) cyc("R8", 1, 0, 0, LO, 0, 0);
    cyc("R8", 0, 1, 0, LO, 0, 0);
    cyc("R8", 0, 0, 1, HI, 32'h100, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic t, r, w;
      logic [7:0] a;
      int s;
      t = ($urandom % 10) < 7;
      r = ($urandom % 10) < 3;
      w = !r && (($urandom % 50) == 0);
      s = $urandom % 8;
      a = (s < 4) ? LO : (s < 7) ? HI : 8'h6C;
      cyc(a == LO ? "R4" : (a == HI ? "R5" : "R9"), t, r, w, w ? HI : a,
          (($urandom % 5) != 0) ? 32'h100 : 32'h0, !r);
    end

    // R3 wrap on narrow instance (4+4 bits)
    bcyc(0, 0, 1, HI, 32'h100);
    for (int i = 0; i < 167; i++) bcyc(1, 0, 0, LO, 0);
    bcyc(0, 1, 0, LO, 0);
    check("R3", b_rdata, 32'h7);
    bcyc(0, 1, 0, HI, 0);
    check("R5", b_rdata, 32'h10A);
    for (int i = 0; i < 92; i++) bcyc(1, 0, 0, LO, 0);
    bcyc(0, 1, 0, LO, 0);
    check("R3", b_rdata, 32'h3);
    bcyc(0, 1, 0, HI, 0);
    check("R3", b_rdata, 32'h100);

    summary();
  end
endmodule